// File: doc/BRIEF.md
# Buffered Flash Write Sequencer

This block accepts a multi-step buffered-programming command protocol on a simple write-strobe bus and copies the collected words into a small on-chip array that behaves like flash cells. A host opens a sequence with a setup command, sends a word count, sends a start address with the first data word, sends the remaining address/data pairs in any order inside the declared window, and finishes with a confirm command. Each step is checked as it arrives. Any protocol, range or boundary violation ends the sequence at once and raises a fixed combination of status bits.

Buffer availability is reported through bit 7 of an extended status byte, which is loaded by every setup command. One confirmed job can wait while the programming engine is still copying an earlier one, so the host can fill the buffer again during a copy. Programming can only clear bits, and the ready bit of the main status byte stays low while a copy is running. Sticky error bits block new sequences until they are cleared by a command.

Top module: `flash_bufwr_seq`

## Requirements
- R1: A setup write (wr_data[7:0] = E8h) while the sequencer is idle loads xstatus_q[7] on the next clock. It is 1 and the sequence starts when no error bit is set and no confirmed job is waiting. Otherwise it is 0 and the sequencer stays idle. All other xstatus_q bits read 0.
- R2: The write after setup carries the word count as N-1 in wr_data[7:0]. A value of BUF_WORDS or more, or an address outside the block named at setup, sets status_q[5] and status_q[4] and returns to idle.
- R3: The next write gives the start address and the first data word. A start address outside the setup block, or a start offset plus N that runs past the end of the block, sets status_q[5] and status_q[4] and programs nothing.
- R4: Each further write must fall within start to start+N-1 and places its word at that address. The last write to an address wins, and addresses that receive no word keep their old contents. An address outside the window sets status_q[5] and status_q[4].
- R5: After N data writes, only D0h starts the copy. Any other value sets status_q[5] and status_q[4] and programs nothing.
- R6: While status_q[4] or status_q[5] is set, setup commands are refused. These bits and status_q[1] stay set until a clear command (50h) is written while idle, which clears all three.
- R7: At confirm, if wp_n is low and the lock bit of the target block is set, status_q[1] and status_q[4] are set and nothing is programmed. When wp_n is high, lock bits are ignored.
- R8: At confirm, if vpp_ok is low, status_q[5] and status_q[4] are set and nothing is programmed. This check is made before the lock check.
- R9: Programming stores the old word AND the new word, so it can only clear bits.
- R10: status_q[7] is 0 from the second clock after the confirm write until the copy ends. Each word takes WORD_CYCLES clocks.
- R11: A setup during a copy is accepted when no job is waiting. A job confirmed during a copy waits and runs afterwards. Setup reads xstatus_q[7] = 0 while a job is waiting.
- R12: After reset, status_q is 80h, xstatus_q is 00h and every array word is all ones. Bits 6, 3, 2 and 0 of status_q always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | 8 | Host word address (block number in the upper bits) |
| wr_data | input | 16 | Host data; commands and count in bits 7:0 |
| wp_n | input | 1 | Write protect; low makes lock bits effective |
| lock_bits | input | 4 | Per-block lock bit |
| vpp_ok | input | 1 | Programming supply good |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 16 | Array read data (combinational) |
| status_q | output | 8 | Status: 7 ready, 5 sequence/supply fault, 4 program fault, 1 lock fault |
| xstatus_q | output | 8 | Extended status: 7 buffer free at last setup |

## Verification
The assertions assume that wr_en is a single-cycle strobe whose address and data are stable at the sampling edge. They also assume that rst_n is held low before the first clock, so no property sees the power-up values. The bench drives every input on the falling edge, holds the strobe for exactly one cycle and asserts reset from time zero. It changes wp_n, lock_bits and vpp_ok only between sequences, so the confirm-time checks always see settled levels.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

   localparam logic [7:0] CMD_BUF_SETUP  = 8'hE8;
   localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
   localparam logic [7:0] CMD_CLR_STATUS = 8'h50;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_COUNT,
      SQ_FIRST,
      SQ_DATA,
      SQ_CONFIRM
   } seq_state_e;

endpackage

// File: rtl/fbw_cmd_seq.sv
module fbw_cmd_seq
   import fbw_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int OFS_W     = 6,
   parameter int DATA_W    = 16,
   parameter int BUF_WORDS = 16,
   parameter int BLK_W     = ADDR_W - OFS_W,
   parameter int IDX_W     = $clog2(BUF_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wp_n_i,
   input  logic [(1<<BLK_W)-1:0] lock_bits_i,
   input  logic              vpp_ok_i,
   input  logic              job_waiting_i,
   output seq_state_e        state_o,
   output logic              buf_init_o,
   output logic              buf_we_o,
   output logic [IDX_W-1:0]  buf_idx_o,
   output logic              launch_o,
   output logic [ADDR_W-1:0] job_base_o,
   output logic [IDX_W-1:0]  job_cnt_o,
   output logic              sr5_o,
   output logic              sr4_o,
   output logic              sr1_o,
   output logic              xsr7_o
);

   seq_state_e        state_q, state_d;
   logic [BLK_W-1:0]  blk_q;
   logic [IDX_W-1:0]  cnt_m1_q;
   logic [IDX_W-1:0]  left_q;
   logic [OFS_W-1:0]  start_ofs_q;
   logic              sr5_q, sr4_q, sr1_q, xsr7_q, launch_q;

   logic [7:0]        cmd;
   logic [BLK_W-1:0]  wr_blk;
   logic [OFS_W-1:0]  wr_ofs;
   logic [OFS_W-1:0]  rel_ofs;
   logic [OFS_W:0]    end_sum;
   logic              same_blk, cnt_ok, crosses, in_window, err_any;
   logic              hit_seq, hit_lock, fire, clr_err, set_xsr, xsr_val;
   logic              ld_setup, ld_cnt, ld_start, step;

   assign cmd       = wr_data_i[7:0];
   assign wr_blk    = wr_addr_i[ADDR_W-1:OFS_W];
   assign wr_ofs    = wr_addr_i[OFS_W-1:0];
   assign same_blk  = (wr_blk == blk_q);
   assign cnt_ok    = ({1'b0, wr_data_i[7:0]} < 9'(BUF_WORDS));
   assign end_sum   = {1'b0, wr_ofs} + {1'b0, OFS_W'(cnt_m1_q)};
   assign crosses   = end_sum[OFS_W];
   assign rel_ofs   = wr_ofs - start_ofs_q;
   assign in_window = same_blk && (wr_ofs >= start_ofs_q) &&
                      (rel_ofs <= OFS_W'(cnt_m1_q));
   assign err_any   = sr4_q | sr5_q;
   assign xsr_val   = !err_any && !job_waiting_i;

   always_comb begin
      state_d    = state_q;
      hit_seq    = 1'b0;
      hit_lock   = 1'b0;
      fire       = 1'b0;
      clr_err    = 1'b0;
      set_xsr    = 1'b0;
      ld_setup   = 1'b0;
      ld_cnt     = 1'b0;
      ld_start   = 1'b0;
      step       = 1'b0;
      buf_init_o = 1'b0;
      buf_we_o   = 1'b0;
      buf_idx_o  = '0;
      if (wr_en_i) begin
         unique case (state_q)
            SQ_IDLE: begin
               if (cmd == CMD_BUF_SETUP) begin
                  set_xsr = 1'b1;
                  if (xsr_val) begin
                     ld_setup   = 1'b1;
                     buf_init_o = 1'b1;
                     state_d    = SQ_COUNT;
                  end
               end else if (cmd == CMD_CLR_STATUS) begin
                  clr_err = 1'b1;
               end
            end
            SQ_COUNT: begin
               if (!same_blk || !cnt_ok) begin
                  hit_seq = 1'b1;
                  state_d = SQ_IDLE;
               end else begin
                  ld_cnt  = 1'b1;
                  state_d = SQ_FIRST;
               end
            end
            SQ_FIRST: begin
               if (!same_blk || crosses) begin
                  hit_seq = 1'b1;
                  state_d = SQ_IDLE;
               end else begin
                  ld_start  = 1'b1;
                  buf_we_o  = 1'b1;
                  buf_idx_o = '0;
                  state_d   = (cnt_m1_q == '0) ? SQ_CONFIRM : SQ_DATA;
               end
            end
            SQ_DATA: begin
               if (!in_window) begin
                  hit_seq = 1'b1;
                  state_d = SQ_IDLE;
               end else begin
                  step      = 1'b1;
                  buf_we_o  = 1'b1;
                  buf_idx_o = rel_ofs[IDX_W-1:0];
                  if (left_q == IDX_W'(1)) state_d = SQ_CONFIRM;
               end
            end
            SQ_CONFIRM: begin
               state_d = SQ_IDLE;
               if (cmd != CMD_CONFIRM)              hit_seq  = 1'b1;
               else if (!vpp_ok_i)                  hit_seq  = 1'b1;
               else if (!wp_n_i && lock_bits_i[blk_q]) hit_lock = 1'b1;
               else                                 fire     = 1'b1;
            end
            default: state_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         blk_q       <= '0;
         cnt_m1_q    <= '0;
         left_q      <= '0;
         start_ofs_q <= '0;
         sr5_q       <= 1'b0;
         sr4_q       <= 1'b0;
         sr1_q       <= 1'b0;
         xsr7_q      <= 1'b0;
         launch_q    <= 1'b0;
      end else begin
         state_q  <= state_d;
         launch_q <= fire;
         if (set_xsr)  xsr7_q      <= xsr_val;
         if (ld_setup) blk_q       <= wr_blk;
         if (ld_cnt)   cnt_m1_q    <= wr_data_i[IDX_W-1:0];
         if (ld_start) begin
            start_ofs_q <= wr_ofs;
            left_q      <= cnt_m1_q;
         end
         if (step)     left_q      <= left_q - IDX_W'(1);
         if (clr_err) begin
            sr5_q <= 1'b0;
            sr4_q <= 1'b0;
            sr1_q <= 1'b0;
         end
         if (hit_seq) begin
            sr5_q <= 1'b1;
            sr4_q <= 1'b1;
         end
         if (hit_lock) begin
            sr1_q <= 1'b1;
            sr4_q <= 1'b1;
         end
      end
   end

   assign state_o    = state_q;
   assign launch_o   = launch_q;
   assign job_base_o = {blk_q, start_ofs_q};
   assign job_cnt_o  = cnt_m1_q;
   assign sr5_o      = sr5_q;
   assign sr4_o      = sr4_q;
   assign sr1_o      = sr1_q;
   assign xsr7_o     = xsr7_q;

endmodule

// File: rtl/fbw_loader_buf.sv
module fbw_loader_buf #(
   parameter int DATA_W    = 16,
   parameter int BUF_WORDS = 16,
   parameter int IDX_W     = $clog2(BUF_WORDS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              init_i,
   input  logic                              we_i,
   input  logic [IDX_W-1:0]                  idx_i,
   input  logic [DATA_W-1:0]                 wdata_i,
   output logic [BUF_WORDS-1:0][DATA_W-1:0]  words_o
);

   for (genvar w = 0; w < BUF_WORDS; w++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  slot_q <= '1;
         else if (init_i)                             slot_q <= '1;
         else if (we_i && (idx_i == IDX_W'(w)))       slot_q <= wdata_i;
      end
      assign words_o[w] = slot_q;
   end

endmodule

// File: rtl/fbw_prog_engine.sv
module fbw_prog_engine #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int BUF_WORDS   = 16,
   parameter int WORD_CYCLES = 4,
   parameter int IDX_W       = $clog2(BUF_WORDS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              launch_i,
   input  logic [ADDR_W-1:0]                 base_i,
   input  logic [IDX_W-1:0]                  cnt_i,
   input  logic [BUF_WORDS-1:0][DATA_W-1:0]  words_i,
   output logic                              busy_o,
   output logic                              waiting_o,
   output logic                              prog_we_o,
   output logic [ADDR_W-1:0]                 prog_addr_o,
   output logic [DATA_W-1:0]                 prog_mask_o
);

   logic                              active_q, waiting_q;
   logic [ADDR_W-1:0]                 base_q;
   logic [IDX_W-1:0]                  cnt_q, idx_q;
   logic [BUF_WORDS-1:0][DATA_W-1:0]  words_q;
   logic                              tick_done, word_done, job_done, free, take_now;

   assign word_done = active_q && tick_done;
   assign job_done  = word_done && (idx_q == cnt_q);
   assign free      = !active_q || job_done;
   assign take_now  = free && (waiting_q || launch_i);

   if (WORD_CYCLES == 1) begin : g_one_cycle
      assign tick_done = 1'b1;
   end else begin : g_multi_cycle
      localparam int PH_W = $clog2(WORD_CYCLES);
      logic [PH_W-1:0] ph_q;
      assign tick_done = (ph_q == PH_W'(WORD_CYCLES - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            ph_q <= '0;
         else if (take_now)     ph_q <= '0;
         else if (active_q)     ph_q <= tick_done ? '0 : ph_q + PH_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         waiting_q <= 1'b0;
         base_q    <= '0;
         cnt_q     <= '0;
         idx_q     <= '0;
         words_q   <= '1;
      end else begin
         waiting_q <= (waiting_q && !take_now) || (launch_i && !free);
         if (take_now) begin
            active_q <= 1'b1;
            base_q   <= base_i;
            cnt_q    <= cnt_i;
            idx_q    <= '0;
            words_q  <= words_i;
         end else if (job_done) begin
            active_q <= 1'b0;
         end else if (word_done) begin
            idx_q    <= idx_q + IDX_W'(1);
         end
      end
   end

   assign busy_o      = active_q | waiting_q;
   assign waiting_o   = waiting_q;
   assign prog_we_o   = word_done;
   assign prog_addr_o = base_q + ADDR_W'(idx_q);
   assign prog_mask_o = words_q[idx_q];

endmodule

// File: rtl/fbw_array.sv
module fbw_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] mask_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] cell_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
      end else if (we_i) begin
         cell_q[waddr_i] <= cell_q[waddr_i] & mask_i;
      end
   end

   assign rdata_o = cell_q[raddr_i];

endmodule

// File: rtl/flash_bufwr_seq.sv
module flash_bufwr_seq
   import fbw_pkg::*;
#(
   parameter  int DATA_W      = 16,
   parameter  int BLOCK_WORDS = 64,
   parameter  int NUM_BLOCKS  = 4,
   parameter  int BUF_WORDS   = 16,
   parameter  int WORD_CYCLES = 4,
   localparam int OFS_W       = $clog2(BLOCK_WORDS),
   localparam int BLK_W       = $clog2(NUM_BLOCKS),
   localparam int ADDR_W      = OFS_W + BLK_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  wp_n,
   input  logic [NUM_BLOCKS-1:0] lock_bits,
   input  logic                  vpp_ok,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   output logic [7:0]            status_q,
   output logic [7:0]            xstatus_q
);

   localparam int IDX_W = $clog2(BUF_WORDS);

   if (DATA_W < 8) begin : g_chk_data
      $error("DATA_W must hold an 8-bit command");
   end
   if (BUF_WORDS < 2 || BUF_WORDS > 128 || (1 << IDX_W) != BUF_WORDS) begin : g_chk_buf
      $error("BUF_WORDS must be a power of two from 2 to 128");
   end
   if (BUF_WORDS > BLOCK_WORDS || (1 << OFS_W) != BLOCK_WORDS) begin : g_chk_blk
      $error("BLOCK_WORDS must be a power of two no smaller than BUF_WORDS");
   end
   if (NUM_BLOCKS < 2 || (1 << BLK_W) != NUM_BLOCKS) begin : g_chk_nblk
      $error("NUM_BLOCKS must be a power of two of at least 2");
   end
   if (WORD_CYCLES < 1) begin : g_chk_cyc
      $error("WORD_CYCLES must be at least 1");
   end

   seq_state_e                        seq_state;
   logic                              buf_init, buf_we, launch;
   logic [IDX_W-1:0]                  buf_idx, job_cnt;
   logic [ADDR_W-1:0]                 job_base, prog_addr;
   logic [BUF_WORDS-1:0][DATA_W-1:0]  buf_words;
   logic                              eng_busy, eng_waiting, prog_we;
   logic [DATA_W-1:0]                 prog_mask;
   logic                              sr5, sr4, sr1, xsr7;

   fbw_cmd_seq #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)
   ) u_cmd_seq (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .wp_n_i(wp_n), .lock_bits_i(lock_bits), .vpp_ok_i(vpp_ok),
      .job_waiting_i(eng_waiting),
      .state_o(seq_state),
      .buf_init_o(buf_init), .buf_we_o(buf_we), .buf_idx_o(buf_idx),
      .launch_o(launch), .job_base_o(job_base), .job_cnt_o(job_cnt),
      .sr5_o(sr5), .sr4_o(sr4), .sr1_o(sr1), .xsr7_o(xsr7)
   );

   fbw_loader_buf #(
      .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)
   ) u_loader (
      .clk(clk), .rst_n(rst_n),
      .init_i(buf_init), .we_i(buf_we), .idx_i(buf_idx),
      .wdata_i(wr_data), .words_o(buf_words)
   );

   fbw_prog_engine #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS),
      .WORD_CYCLES(WORD_CYCLES)
   ) u_engine (
      .clk(clk), .rst_n(rst_n),
      .launch_i(launch), .base_i(job_base), .cnt_i(job_cnt),
      .words_i(buf_words),
      .busy_o(eng_busy), .waiting_o(eng_waiting),
      .prog_we_o(prog_we), .prog_addr_o(prog_addr), .prog_mask_o(prog_mask)
   );

   fbw_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .we_i(prog_we), .waddr_i(prog_addr), .mask_i(prog_mask),
      .raddr_i(rd_addr), .rdata_o(rd_data)
   );

   assign status_q  = {~eng_busy, 1'b0, sr5, sr4, 2'b00, sr1, 1'b0};
   assign xstatus_q = {xsr7, 7'b0};

endmodule

// File: rtl/fbw_checker.sv
module fbw_checker
   import fbw_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] cmd,
   input seq_state_e seq_state,
   input logic       launch,
   input logic       waiting,
   input logic [7:0] status,
   input logic [7:0] xstatus
);

   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[4] && !(wr_en && cmd == CMD_CLR_STATUS && seq_state == SQ_IDLE))
      |=> status[4]);

   a_r6_setup_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cmd == CMD_BUF_SETUP && seq_state == SQ_IDLE && (status[4] || status[5]))
      |=> (!xstatus[7] && seq_state == SQ_IDLE));

   a_r11_no_buffer_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cmd == CMD_BUF_SETUP && seq_state == SQ_IDLE && waiting)
      |=> !xstatus[7]);

   a_r10_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !status[7]);

   a_r7_lock_fault_pairs: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[1]) |-> status[4]);

   a_r8_seq_fault_pairs: assert property (@(posedge clk) disable iff (!rst_n)
      status[5] |-> status[4]);

   a_r1_setup_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == SQ_IDLE && $rose(xstatus[7])) |-> (seq_state == SQ_IDLE) == 1'b0);

endmodule

bind flash_bufwr_seq fbw_checker u_fbw_checker (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd(wr_data[7:0]),
   .seq_state(seq_state), .launch(launch), .waiting(eng_waiting),
   .status(status_q), .xstatus(xstatus_q)
);

// File: tb/test_flash_bufwr_seq.sv
module test_flash_bufwr_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        wp_n = 1'b1;
   logic [3:0]  lock_bits = '0;
   logic        vpp_ok = 1'b1;
   logic [7:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [7:0]  status_q, xstatus_q;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   flash_bufwr_seq i_flash_bufwr_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wp_n(wp_n), .lock_bits(lock_bits), .vpp_ok(vpp_ok),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .status_q(status_q), .xstatus_q(xstatus_q)
   );

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic peek(input string req, input logic [7:0] a, input logic [15:0] exp);
      rd_addr = a;
      #1;
      chk(req, $sformatf("array[%h]", a), rd_data, exp);
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 2000; i++) begin
         if (status_q[7]) break;
         @(negedge clk);
      end
   endtask

   task automatic clear_status();
      bus_wr(8'h00, 16'h0050);
   endtask

   // setup, count, then n consecutive words from start, then the final command
   task automatic load_job(input logic [7:0] start, input int n,
                           input logic [15:0] d0, input logic [15:0] fin);
      bus_wr(start, 16'h00E8);
      bus_wr(start, 16'(n - 1));
      for (int i = 0; i < n; i++) bus_wr(start + 8'(i), d0 + 16'(i));
      bus_wr(start, fin);
   endtask

   task automatic t_reset();
      chk("R12", "status after reset", {8'h0, status_q}, 16'h0080);
      chk("R12", "xstatus after reset", {8'h0, xstatus_q}, 16'h0000);
      peek("R12", 8'h00, 16'hFFFF);
      peek("R12", 8'hFF, 16'hFFFF);
   endtask

   task automatic t_basic();
      bus_wr(8'h40, 16'h00E8);
      chk("R1", "xstatus after setup", {8'h0, xstatus_q}, 16'h0080);
      bus_wr(8'h45, 16'h0003);
      bus_wr(8'h48, 16'h1234);
      bus_wr(8'h49, 16'h5678);
      bus_wr(8'h4A, 16'h9ABC);
      bus_wr(8'h4B, 16'h0F0F);
      bus_wr(8'h40, 16'h00D0);
      @(negedge clk);
      chk("R10", "status during copy", {8'h0, status_q}, 16'h0000);
      wait_ready();
      chk("R10", "status after copy", {8'h0, status_q}, 16'h0080);
      peek("R3", 8'h48, 16'h1234);
      peek("R4", 8'h49, 16'h5678);
      peek("R4", 8'h4B, 16'h0F0F);
      peek("R4", 8'h47, 16'hFFFF);
      peek("R4", 8'h4C, 16'hFFFF);
   endtask

   task automatic t_and_and_timing();
      int busy_cnt = 0;
      load_job(8'h48, 1, 16'hFF00, 16'h00D0);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (!status_q[7]) busy_cnt++;
         else if (busy_cnt > 0) break;
      end
      chk("R10", "busy cycles for one word", 16'(busy_cnt), 16'd4);
      peek("R9", 8'h48, 16'h1200);
   endtask

   task automatic t_window_order();
      bus_wr(8'h60, 16'h00E8);
      bus_wr(8'h60, 16'h0002);
      bus_wr(8'h60, 16'h00AA);
      bus_wr(8'h62, 16'h00CC);
      bus_wr(8'h62, 16'h00DD);
      bus_wr(8'h60, 16'h00D0);
      @(negedge clk);
      wait_ready();
      peek("R4", 8'h60, 16'h00AA);
      peek("R4", 8'h61, 16'hFFFF);
      peek("R4", 8'h62, 16'h00DD);
   endtask

   task automatic t_bad_confirm();
      load_job(8'h81, 1, 16'h0000, 16'h00FF);
      chk("R5", "status after bad confirm", {8'h0, status_q}, 16'h00B0);
      @(negedge clk);
      peek("R5", 8'h81, 16'hFFFF);
      bus_wr(8'h80, 16'h00E8);
      chk("R6", "setup refused on error", {8'h0, xstatus_q}, 16'h0000);
      chk("R6", "error bits held", {8'h0, status_q}, 16'h00B0);
      clear_status();
      chk("R6", "status after clear", {8'h0, status_q}, 16'h0080);
   endtask

   task automatic t_boundary();
      bus_wr(8'h40, 16'h00E8);
      bus_wr(8'h40, 16'h0003);
      bus_wr(8'h7E, 16'h0000);
      chk("R3", "status on block crossing", {8'h0, status_q}, 16'h00B0);
      peek("R3", 8'h7E, 16'hFFFF);
      clear_status();
      bus_wr(8'h40, 16'h00E8);
      bus_wr(8'h40, 16'h0000);
      bus_wr(8'h05, 16'h0000);
      chk("R3", "status on foreign start block", {8'h0, status_q}, 16'h00B0);
      clear_status();
   endtask

   task automatic t_count();
      bus_wr(8'h40, 16'h00E8);
      bus_wr(8'h40, 16'h0010);
      chk("R2", "status on count too big", {8'h0, status_q}, 16'h00B0);
      clear_status();
      bus_wr(8'h40, 16'h00E8);
      bus_wr(8'h00, 16'h0000);
      chk("R2", "status on count outside block", {8'h0, status_q}, 16'h00B0);
      clear_status();
   endtask

   task automatic t_out_of_window();
      bus_wr(8'h00, 16'h00E8);
      bus_wr(8'h00, 16'h0001);
      bus_wr(8'h10, 16'h0001);
      bus_wr(8'h15, 16'h0002);
      chk("R4", "status on address outside window", {8'h0, status_q}, 16'h00B0);
      peek("R4", 8'h10, 16'hFFFF);
      clear_status();
   endtask

   task automatic t_lock();
      lock_bits = 4'b0100;
      wp_n = 1'b0;
      load_job(8'h88, 1, 16'h0000, 16'h00D0);
      chk("R7", "status on locked block", {8'h0, status_q}, 16'h0092);
      @(negedge clk);
      peek("R7", 8'h88, 16'hFFFF);
      clear_status();
      chk("R7", "status after clear", {8'h0, status_q}, 16'h0080);
      wp_n = 1'b1;
      load_job(8'h88, 1, 16'h0000, 16'h00D0);
      @(negedge clk);
      wait_ready();
      peek("R7", 8'h88, 16'h0000);
      chk("R7", "no fault with wp_n high", {8'h0, status_q}, 16'h0080);
   endtask

   task automatic t_vpp();
      vpp_ok = 1'b0;
      wp_n = 1'b0;
      load_job(8'h89, 1, 16'h0000, 16'h00D0);
      chk("R8", "status with supply low", {8'h0, status_q}, 16'h00B0);
      @(negedge clk);
      peek("R8", 8'h89, 16'hFFFF);
      clear_status();
      vpp_ok = 1'b1;
      wp_n = 1'b1;
      lock_bits = '0;
   endtask

   task automatic t_overlap();
      load_job(8'hC0, 16, 16'h1100, 16'h00D0);
      bus_wr(8'hD0, 16'h00E8);
      chk("R11", "setup accepted during copy", {8'h0, xstatus_q}, 16'h0080);
      chk("R11", "still busy", {15'h0, status_q[7]}, 16'h0000);
      bus_wr(8'hD0, 16'h0000);
      bus_wr(8'hD0, 16'h5555);
      bus_wr(8'hD0, 16'h00D0);
      bus_wr(8'hD0, 16'h00E8);
      chk("R11", "no buffer while job waits", {8'h0, xstatus_q}, 16'h0000);
      wait_ready();
      peek("R11", 8'hC0, 16'h1100);
      peek("R11", 8'hCF, 16'h110F);
      peek("R11", 8'hD0, 16'h5555);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_and_and_timing();
      t_window_order();
      t_bad_confirm();
      t_boundary();
      t_count();
      t_out_of_window();
      t_lock();
      t_vpp();
      t_overlap();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule